// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking an in-memory translation tree. It starts from a context-table pointer and a context number. It then fetches one 32-bit table word at a time over a simple request/response memory port, and follows directory entries down through at most three levels below the context table. A leaf found at level 1, 2 or 3 maps a 16 MB, 256 KB or 4 KB page. Each walk ends with either a translation (physical address, page size, final entry, access rights) or a fault code. The fault code records the level where the walk stopped and the kind of failure.

The walker handles one request at a time. Before it accepts a leaf, it shows the leaf's access field and the kind of access on a permission hook. Logic outside the block answers in the same cycle with a fault type or a rights vector. When the leaf's referenced mark needs setting, or a store meets a clean page, the walker writes the updated entry back to the address it was read from. A bypass mode skips the tables entirely. In bypass mode a boot flag redirects instruction fetches into a boot-ROM window.

Top module: `ptw_walker`

## Requirements
- R1: The first table read of a walk goes to address (cfg_ctp << 4) + (cfg_ctx << 2).
- R2: A directory entry (type bits 1:0 = 1) found at level L (L = 0, 1, 2) leads to a read at level L+1 of address ((entry & ~3) << 4) + index. The index is vaddr[31:24]*4 for level 1, vaddr[23:18]*4 for level 2 and vaddr[17:12]*4 for level 3.
- R3: A leaf entry (type 2) at level 1, 2 or 3 yields xl_paddr = (entry[31:8] << 12) + offset. The offset is vaddr[23:12] << 12, vaddr[17:12] << 12 or 0 respectively. xl_size is 2, 1 or 0 respectively (16 MB, 256 KB, 4 KB). xl_pte holds the final entry.
- R4: A fault reports xl_ok = 0 and xl_fault = (level << 8) | (type << 2), with all other bits zero. An invalid entry (type 0) read at level L gives type 1 at level L.
- R5: Type 4 (translation error) at level L is reported in four cases: a read with mem_err set at level L, a reserved entry (type 3) at level L, a leaf in the context table (level 0), and a directory entry at level 3.
- R6: A leaf is written back to its own address when its referenced bit 5 is clear, or when the access is a store and its modified bit 6 is clear. The written value sets bit 5, and also bit 6 for a store. No write happens otherwise, and xl_pte shows the written value.
- R7: While chk_valid is high, chk_acc shows the leaf's bits 4:2. A nonzero chk_fault then ends the walk with fault (level << 8) | (chk_fault << 2) and no write-back. Otherwise xl_rights takes chk_rights (bit 2 read, bit 1 write, bit 0 execute).
- R8: With cfg_bypass set, no memory access is made and done rises one cycle after the request. An instruction fetch with cfg_boot set gives xl_paddr = cfg_prom_base | vaddr[18:0] with xl_rights = 3'b101. Any other bypassed access gives xl_paddr = vaddr zero-extended and xl_rights = 3'b111.
- R9: busy is high from the cycle after an accepted table walk until done. done is a one-cycle pulse with either xl_ok = 1 or a nonzero fault. req_valid is ignored while busy.
- R10: mem_req, mem_we and mem_addr stay stable until mem_rsp_valid. mem_req is low whenever the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| cfg_bypass | input | 1 | Skip the tables (physical mode) |
| cfg_boot | input | 1 | Boot flag: bypassed fetches go to the ROM window |
| cfg_prom_base | input | 36 | Base of the boot-ROM window |
| cfg_ctp | input | 32 | Context-table pointer |
| cfg_ctx | input | CTX_W | Context number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the pending access |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Bus error on the pending access |
| chk_valid | output | 1 | Permission hook query is valid |
| chk_acc | output | 3 | Leaf access field (bits 4:2) |
| chk_store | output | 1 | Queried access is a store |
| chk_fetch | output | 1 | Queried access is a fetch |
| chk_user | output | 1 | Queried access is in user mode |
| chk_fault | input | 3 | Hook answer: fault type, 0 for allowed |
| chk_rights | input | 3 | Hook answer: granted rights |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| xl_ok | output | 1 | Translation succeeded |
| xl_paddr | output | 36 | Physical address |
| xl_size | output | 2 | Page size code |
| xl_pte | output | 32 | Final entry |
| xl_rights | output | 3 | Granted rights |
| xl_fault | output | 10 | Fault code |

## Verification
The assertions assume a memory that answers each pending access once, with a response pulse, and never answers when no access is pending. The bench responder follows this rule, with a latency chosen per walk. The assertions also assume that chk_fault and chk_rights depend only on the hook outputs during that cycle. The bench hook is a pure combinational function of chk_acc and chk_store. Any request raised during a walk is held for a single cycle only, which exercises the ignore rule without building a queue.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 36;
    localparam int PTE_W    = 32;
    localparam int LEVELS   = 3;
    localparam int LVL_W    = 2;
    localparam int FC_W     = 10;
    localparam int ROM_OFF_W = 19;
    localparam int PG_SH    = 12;
    localparam int VPN_W    = VA_W - PG_SH;
    localparam int PPN_W    = PTE_W - 8;
    localparam int PTR_W    = PTE_W - 2;
    localparam int REF_BIT  = 5;
    localparam int MOD_BIT  = 6;

    typedef enum logic [1:0] {
        ENT_INVALID = 2'd0,
        ENT_DIR     = 2'd1,
        ENT_LEAF    = 2'd2,
        ENT_RSVD    = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_256K = 2'd1,
        PG_16M  = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WRITE
    } walk_st_e;

    typedef enum logic [1:0] {
        ACT_DESCEND,
        ACT_LEAF,
        ACT_INVALID,
        ACT_XLERR
    } step_act_e;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLERR   = 3'd4;

    typedef struct packed {
        logic              ok;
        logic [PA_W-1:0]   paddr;
        pg_size_e          size;
        logic [PTE_W-1:0]  pte;
        logic [2:0]        rights;
        logic [FC_W-1:0]   fault;
    } xl_result_t;

    function automatic logic [FC_W-1:0] make_fault(input logic [LVL_W-1:0] lvl,
                                                   input logic [2:0] ftype);
        return {lvl, 3'b000, ftype, 2'b00};
    endfunction

    function automatic logic [PA_W-1:0] dir_base(input logic [PTR_W-1:0] ptr);
        return {ptr, 6'b000000};
    endfunction

    function automatic logic [PA_W-1:0] page_base(input logic [PPN_W-1:0] ppn);
        return {ppn, {PG_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_step_class.sv
module ptw_step_class
    import ptw_pkg::*;
(
    input  logic [1:0]       kind_bits,
    input  logic [LVL_W-1:0] lvl,
    input  logic             bus_err,
    output step_act_e        act
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS);

    always_comb begin
        if (bus_err) begin
            act = ACT_XLERR;
        end else begin
            unique case (ent_kind_e'(kind_bits))
                ENT_INVALID: act = ACT_INVALID;
                ENT_RSVD:    act = ACT_XLERR;
                ENT_LEAF:    act = (lvl == '0) ? ACT_XLERR : ACT_LEAF;
                ENT_DIR:     act = (lvl == LAST_LVL) ? ACT_XLERR : ACT_DESCEND;
                default:     act = ACT_XLERR;
            endcase
        end
    end

    // R5: a directory may never lead below the last level
    always_comb begin
        if (!bus_err && lvl == LAST_LVL)
            AST_NO_DEEPER: assert (act != ACT_DESCEND); // R5
    end

endmodule

// File: rtl/ptw_addr_unit.sv
module ptw_addr_unit
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [31:0]       ctp,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [PTR_W-1:0]  dir_ptr,
    input  logic [PPN_W-1:0]  leaf_ppn,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [LVL_W-1:0]  lvl,
    output logic [PA_W-1:0]   first_addr,
    output logic [PA_W-1:0]   next_addr,
    output logic [PA_W-1:0]   leaf_paddr,
    output pg_size_e          leaf_size
);
    localparam int IDX_W = 10;
    localparam int OFF_W = 24;

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;

    assign first_addr = {ctp, 4'b0000} + PA_W'({ctx, 2'b00});

    // R2: index into the table one level below lvl
    always_comb begin
        unique case (lvl)
            2'd0:    idx = {vpn[19:12], 2'b00};
            2'd1:    idx = {2'b00, vpn[11:6], 2'b00};
            2'd2:    idx = {2'b00, vpn[5:0], 2'b00};
            default: idx = '0;
        endcase
    end

    assign next_addr = dir_base(dir_ptr) + PA_W'(idx);

    // R3: offset carried through from the virtual address
    always_comb begin
        unique case (lvl)
            2'd1: begin
                off       = {vpn[11:0], 12'h000};
                leaf_size = PG_16M;
            end
            2'd2: begin
                off       = {6'b000000, vpn[5:0], 12'h000};
                leaf_size = PG_256K;
            end
            default: begin
                off       = '0;
                leaf_size = PG_4K;
            end
        endcase
    end

    assign leaf_paddr = page_base(leaf_ppn) + PA_W'(off);

endmodule

// File: rtl/ptw_bypass.sv
module ptw_bypass
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic            fetch,
    input  logic            boot,
    input  logic [PA_W-1:0] rom_base,
    output logic [PA_W-1:0] paddr,
    output logic [2:0]      rights
);
    always_comb begin
        if (fetch && boot) begin
            paddr  = rom_base | PA_W'(vaddr[ROM_OFF_W-1:0]);
            rights = 3'b101;
        end else begin
            paddr  = PA_W'(vaddr);
            rights = 3'b111;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic              req_store,
    input  logic              req_fetch,
    input  logic              req_user,
    input  logic              cfg_bypass,
    input  logic              cfg_boot,
    input  logic [35:0]       cfg_prom_base,
    input  logic [31:0]       cfg_ctp,
    input  logic [CTX_W-1:0]  cfg_ctx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [35:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              chk_valid,
    output logic [2:0]        chk_acc,
    output logic              chk_store,
    output logic              chk_fetch,
    output logic              chk_user,
    input  logic [2:0]        chk_fault,
    input  logic [2:0]        chk_rights,
    output logic              busy,
    output logic              done,
    output logic              xl_ok,
    output logic [35:0]       xl_paddr,
    output logic [1:0]        xl_size,
    output logic [31:0]       xl_pte,
    output logic [2:0]        xl_rights,
    output logic [9:0]        xl_fault
);

    walk_st_e          st_q, st_n;
    logic [LVL_W-1:0]  lvl_q, lvl_n;
    logic [PA_W-1:0]   addr_q, addr_n;
    logic [PTE_W-1:0]  ent_q, ent_n;
    logic [VPN_W-1:0]  vpn_q;
    logic              store_q, fetch_q, user_q;
    logic [2:0]        rights_q, rights_n;
    logic              done_q;
    xl_result_t        res_q;

    logic              fin, fin_ok;
    logic [2:0]        fin_type;
    logic              need_wb;
    logic [PTE_W-1:0]  marked;

    step_act_e         act;
    logic [PA_W-1:0]   first_addr, next_addr, leaf_paddr;
    pg_size_e          leaf_size;
    logic [PA_W-1:0]   byp_paddr;
    logic [2:0]        byp_rights;

    ptw_step_class u_class (
        .kind_bits (mem_rdata[1:0]),
        .lvl       (lvl_q),
        .bus_err   (mem_err),
        .act       (act)
    );

    ptw_addr_unit #(.CTX_W(CTX_W)) u_addr (
        .ctp        (cfg_ctp),
        .ctx        (cfg_ctx),
        .dir_ptr    (mem_rdata[PTE_W-1:2]),
        .leaf_ppn   (ent_q[PTE_W-1:8]),
        .vpn        (vpn_q),
        .lvl        (lvl_q),
        .first_addr (first_addr),
        .next_addr  (next_addr),
        .leaf_paddr (leaf_paddr),
        .leaf_size  (leaf_size)
    );

    ptw_bypass u_byp (
        .vaddr    (req_vaddr),
        .fetch    (req_fetch),
        .boot     (cfg_boot),
        .rom_base (cfg_prom_base),
        .paddr    (byp_paddr),
        .rights   (byp_rights)
    );

    // R6: write-back is needed for an unreferenced leaf or a store to a clean page
    assign need_wb = !ent_q[REF_BIT] || (store_q && !ent_q[MOD_BIT]);
    always_comb begin
        marked = ent_q;
        marked[REF_BIT] = 1'b1;
        if (store_q) marked[MOD_BIT] = 1'b1;
    end

    always_comb begin
        st_n     = st_q;
        lvl_n    = lvl_q;
        addr_n   = addr_q;
        ent_n    = ent_q;
        rights_n = rights_q;
        fin      = 1'b0;
        fin_ok   = 1'b0;
        fin_type = 3'd0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid && !cfg_bypass) begin
                    st_n   = ST_READ;
                    addr_n = first_addr;
                    lvl_n  = '0;
                end
            end
            ST_READ: begin
                if (mem_rsp_valid) begin
                    ent_n = mem_rdata;
                    unique case (act)
                        ACT_DESCEND: begin
                            addr_n = next_addr;
                            lvl_n  = lvl_q + 1'b1;
                        end
                        ACT_LEAF: st_n = ST_CHECK;
                        ACT_INVALID: begin
                            fin      = 1'b1;
                            fin_type = FT_INVALID;
                            st_n     = ST_IDLE;
                        end
                        default: begin
                            fin      = 1'b1;
                            fin_type = FT_XLERR;
                            st_n     = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_CHECK: begin
                if (chk_fault != 3'd0) begin
                    fin      = 1'b1;
                    fin_type = chk_fault;
                    st_n     = ST_IDLE;
                end else begin
                    rights_n = chk_rights;
                    if (need_wb) begin
                        ent_n = marked;
                        st_n  = ST_WRITE;
                    end else begin
                        fin    = 1'b1;
                        fin_ok = 1'b1;
                        st_n   = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_rsp_valid) begin
                    fin  = 1'b1;
                    st_n = ST_IDLE;
                    if (mem_err) fin_type = FT_XLERR;
                    else         fin_ok   = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            lvl_q    <= '0;
            addr_q   <= '0;
            ent_q    <= '0;
            vpn_q    <= '0;
            store_q  <= 1'b0;
            fetch_q  <= 1'b0;
            user_q   <= 1'b0;
            rights_q <= '0;
            done_q   <= 1'b0;
            res_q    <= '0;
        end else begin
            st_q     <= st_n;
            lvl_q    <= lvl_n;
            addr_q   <= addr_n;
            ent_q    <= ent_n;
            rights_q <= rights_n;
            done_q   <= 1'b0;
            if (st_q == ST_IDLE && req_valid) begin
                vpn_q   <= req_vaddr[VA_W-1:PG_SH];
                store_q <= req_store;
                fetch_q <= req_fetch;
                user_q  <= req_user;
                if (cfg_bypass) begin
                    done_q       <= 1'b1;
                    res_q.ok     <= 1'b1;
                    res_q.paddr  <= byp_paddr;
                    res_q.size   <= PG_4K;
                    res_q.pte    <= '0;
                    res_q.rights <= byp_rights;
                    res_q.fault  <= '0;
                end
            end else if (fin) begin
                done_q       <= 1'b1;
                res_q.ok     <= fin_ok;
                res_q.paddr  <= fin_ok ? leaf_paddr : '0;
                res_q.size   <= fin_ok ? leaf_size : PG_4K;
                res_q.pte    <= ent_n;
                res_q.rights <= fin_ok ? rights_n : 3'd0;
                res_q.fault  <= fin_ok ? '0 : make_fault(lvl_q, fin_type);
            end
        end
    end

    assign mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
    assign mem_we    = (st_q == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_wdata = ent_q;

    assign chk_valid = (st_q == ST_CHECK);
    assign chk_acc   = ent_q[4:2];
    assign chk_store = store_q;
    assign chk_fetch = fetch_q;
    assign chk_user  = user_q;

    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign xl_ok     = res_q.ok;
    assign xl_paddr  = res_q.paddr;
    assign xl_size   = res_q.size;
    assign xl_pte    = res_q.pte;
    assign xl_rights = res_q.rights;
    assign xl_fault  = res_q.fault;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_DONE_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done |-> (xl_ok != (xl_fault != '0))); // R9
    AST_FAULT_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (done && !xl_ok) |-> (xl_fault[1:0] == 2'b00 && xl_fault[7:5] == 3'b000)); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R10
    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req && mem_we) |-> $stable(mem_addr)); // R6
    AST_WB_MARKED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[REF_BIT]); // R6

endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_fetch, req_user;
    logic [31:0] req_vaddr;
    logic        cfg_bypass, cfg_boot;
    logic [35:0] cfg_prom_base;
    logic [31:0] cfg_ctp;
    logic [7:0]  cfg_ctx;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rdata;
    logic        mem_err;
    logic        chk_valid, chk_store, chk_fetch, chk_user;
    logic [2:0]  chk_acc, chk_fault, chk_rights;
    logic        busy, done, xl_ok;
    logic [35:0] xl_paddr;
    logic [1:0]  xl_size;
    logic [31:0] xl_pte;
    logic [2:0]  xl_rights;
    logic [9:0]  xl_fault;

    ptw_walker #(.CTX_W(8)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // permission hook owned by the bench: stores to access field 0 are refused
    assign chk_fault  = (chk_valid && chk_store && chk_acc == 3'd0) ? 3'd2 : 3'd0;
    assign chk_rights = {1'b1, chk_acc != 3'd0, chk_acc[1]};

    logic [31:0] mem  [logic [35:0]];
    bit          errs [logic [35:0]];
    logic [35:0] seen_rd[$];
    logic [35:0] exp_rd[$];
    int lat = 0;
    int cnt = 0;
    int wr_count = 0;
    int done_count = 0;
    logic [35:0] last_wa;
    logic [31:0] last_wd;
    int tests = 0;
    int fails = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_err       <= 1'b0;
            mem_rdata     <= '0;
            cnt           <= 0;
        end else if (mem_req && !mem_rsp_valid) begin
            if (cnt >= lat) begin
                mem_rsp_valid <= 1'b1;
                cnt           <= 0;
                mem_err       <= errs.exists(mem_addr);
                mem_rdata     <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                if (mem_we) begin
                    if (!errs.exists(mem_addr)) mem[mem_addr] = mem_wdata;
                    wr_count = wr_count + 1;
                    last_wa  = mem_addr;
                    last_wd  = mem_wdata;
                end else begin
                    seen_rd.push_back(mem_addr);
                end
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            mem_rsp_valid <= 1'b0;
        end
        if (!rst && done) done_count = done_count + 1;
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural walk over the bench memory
    task automatic model(input logic [31:0] va, input bit st,
                         output bit ok, output int fault, output logic [35:0] pa,
                         output logic [1:0] sz, output logic [31:0] pte,
                         output logic [2:0] rt, output bit wb, output logic [35:0] la);
        logic [35:0] a;
        logic [31:0] e;
        ok = 0; fault = 0; pa = '0; sz = '0; pte = '0; rt = '0; wb = 0; la = '0;
        exp_rd.delete();
        a = {cfg_ctp, 4'b0000} + {26'b0, cfg_ctx, 2'b00};
        for (int l = 0; l < 4; l++) begin
            exp_rd.push_back(a);
            if (errs.exists(a)) begin fault = l * 256 + 16; return; end
            e = mem.exists(a) ? mem[a] : 32'h0;
            if (e[1:0] == 2'd0) begin fault = l * 256 + 4; return; end
            if (e[1:0] == 2'd3) begin fault = l * 256 + 16; return; end
            if (e[1:0] == 2'd1) begin
                if (l == 3) begin fault = 3 * 256 + 16; return; end
                if (l == 0)      a = {e[31:2], 6'b0} + {26'b0, va[31:24], 2'b00};
                else if (l == 1) a = {e[31:2], 6'b0} + {28'b0, va[23:18], 2'b00};
                else             a = {e[31:2], 6'b0} + {28'b0, va[17:12], 2'b00};
            end else begin
                if (l == 0) begin fault = 16; return; end
                pte = e;
                la  = a;
                if (st && e[4:2] == 3'd0) begin fault = l * 256 + 8; return; end
                rt = {1'b1, e[4:2] != 3'd0, e[3]};
                wb = !e[5] || (st && !e[6]);
                if (wb) pte = e | 32'h20 | (st ? 32'h40 : 32'h0);
                pa = {e[31:8], 12'h000};
                if (l == 1)      begin pa = pa + {12'b0, va[23:12], 12'h000}; sz = 2'd2; end
                else if (l == 2) begin pa = pa + {18'b0, va[17:12], 12'h000}; sz = 2'd1; end
                else             sz = 2'd0;
                ok = 1;
                return;
            end
        end
    endtask

    task automatic walk(input string tag, input logic [31:0] va, input bit st,
                        input bit fe, input bit byp, input bit boot, input bit inject);
        bit ok_e, wb_e, busy_bad;
        int f_e, w0, d0, n;
        logic [35:0] pa_e, la_e;
        logic [1:0]  sz_e;
        logic [31:0] pte_e;
        logic [2:0]  rt_e;
        if (byp) begin
            ok_e = 1; f_e = 0; sz_e = 0; pte_e = 0; wb_e = 0; la_e = 0;
            exp_rd.delete();
            if (fe && boot) begin pa_e = cfg_prom_base | {17'b0, va[18:0]}; rt_e = 3'b101; end
            else            begin pa_e = {4'b0, va}; rt_e = 3'b111; end
        end else begin
            model(va, st, ok_e, f_e, pa_e, sz_e, pte_e, rt_e, wb_e, la_e);
        end
        seen_rd.delete();
        w0 = wr_count; d0 = done_count; busy_bad = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_store = st; req_fetch = fe;
        cfg_bypass = byp; cfg_boot = boot;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!done && n < 400) begin
            if (!busy) busy_bad = 1;
            if (inject && n == 1) begin
                req_valid = 1; req_vaddr = 32'hFFFF_F000; cfg_bypass = 1;
            end else begin
                req_valid = 0; cfg_bypass = byp;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 0;
        check("R9", {tag, " done seen"}, done, 1);
        check("R9", {tag, " busy held"}, busy_bad, 0);
        check("R4", {tag, " ok"}, xl_ok, ok_e);
        check("R4", {tag, " fault"}, xl_fault, f_e);
        if (ok_e) begin
            check(byp ? "R8" : "R3", {tag, " paddr"}, xl_paddr, pa_e);
            check(byp ? "R8" : "R3", {tag, " size"}, xl_size, sz_e);
            check(byp ? "R8" : "R7", {tag, " rights"}, xl_rights, rt_e);
        end
        if (!byp && pte_e != 0) check("R3", {tag, " pte"}, xl_pte, pte_e);
        check("R2", {tag, " read count"}, seen_rd.size(), exp_rd.size());
        if (seen_rd.size() > 0 && exp_rd.size() > 0)
            check("R1", {tag, " first read"}, seen_rd[0], exp_rd[0]);
        for (int i = 0; i < seen_rd.size() && i < exp_rd.size(); i++)
            check("R2", {tag, " read addr"}, seen_rd[i], exp_rd[i]);
        check("R6", {tag, " writes"}, wr_count - w0, wb_e ? 1 : 0);
        if (wb_e) begin
            check("R6", {tag, " wb addr"}, last_wa, la_e);
            check("R6", {tag, " wb data"}, last_wd, pte_e);
        end
        @(negedge clk);
        check("R9", {tag, " single done"}, done_count - d0, 1);
        check("R10", {tag, " idle quiet"}, mem_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_vaddr = 0; req_store = 0; req_fetch = 0; req_user = 0;
        cfg_bypass = 0; cfg_boot = 0; cfg_prom_base = 36'hF_F000_0000;
        cfg_ctp = 32'h100; cfg_ctx = 8'd3;
        // context table at 0x1000
        mem[36'h100C] = 32'h0000_0201;      // ctx 3 -> level-1 table 0x2000
        mem[36'h1010] = 32'h0000_1202;      // ctx 4: leaf in context table
        mem[36'h1014] = 32'h0000_0000;      // ctx 5: invalid
        errs[36'h1018] = 1;                 // ctx 6: bus error
        mem[36'h101C] = 32'h0000_0003;      // ctx 7: reserved
        // level-1 table
        mem[36'h2004] = 32'h000A_BC06;      // 16 MB leaf, acc 1
        mem[36'h2008] = 32'h0000_0301;      // -> level-2 table 0x3000
        mem[36'h2010] = 32'h0000_0000;
        mem[36'h2014] = 32'h0000_0003;
        mem[36'h2020] = 32'h0000_0701;      // -> 0x7000, which errors
        errs[36'h7000] = 1;
        // level-2 table
        mem[36'h3014] = 32'h1234_002E;      // 256 KB leaf, acc 3, referenced
        mem[36'h3018] = 32'h0000_0401;      // -> level-3 table 0x4000
        mem[36'h301C] = 32'h0000_0000;
        // level-3 table
        mem[36'h401C] = 32'h00BE_EF02;      // 4 KB leaf, acc 0
        mem[36'h4020] = 32'h0000_0003;
        mem[36'h4024] = 32'h0000_0501;
        mem[36'h4028] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        check("R9", "reset busy", busy, 0);
        check("R9", "reset done", done, 0);
        check("R10", "reset mem_req", mem_req, 0);
        rst = 0;
        @(negedge clk);

        walk("R8 bypass load", 32'h8765_4321, 0, 0, 1, 0, 0);
        walk("R8 boot fetch", 32'h1237_ABCD, 0, 1, 1, 1, 0);
        walk("R8 boot load", 32'h1237_ABCD, 0, 0, 1, 1, 0);
        lat = 0;
        walk("R3 16M load wb", 32'h0134_5678, 0, 0, 0, 0, 0);
        walk("R6 16M again", 32'h0134_5000, 0, 0, 0, 0, 0);
        lat = 2;
        walk("R3 256K load", 32'h0216_A123, 0, 0, 0, 0, 1);
        walk("R6 256K store", 32'h0216_A000, 1, 0, 0, 0, 0);
        walk("R6 256K store2", 32'h0216_A000, 1, 0, 0, 0, 0);
        lat = 1;
        walk("R7 4K store refused", 32'h0218_7ABC, 1, 0, 0, 0, 0);
        walk("R3 4K load", 32'h0218_7ABC, 0, 1, 0, 0, 0);
        walk("R4 invalid L1", 32'h0400_0000, 0, 0, 0, 0, 0);
        walk("R5 reserved L1", 32'h0500_0000, 0, 0, 0, 0, 0);
        walk("R5 bus err L2", 32'h0800_0000, 0, 0, 0, 0, 0);
        walk("R4 invalid L2", 32'h021C_0000, 0, 0, 0, 0, 0);
        walk("R5 reserved L3", 32'h0218_8000, 0, 0, 0, 0, 0);
        walk("R5 dir at L3", 32'h0218_9000, 0, 0, 0, 0, 0);
        walk("R4 invalid L3", 32'h0218_A000, 0, 0, 0, 0, 0);
        cfg_ctx = 8'd4; walk("R5 leaf in ctx", 32'h0100_0000, 0, 0, 0, 0, 0);
        cfg_ctx = 8'd5; walk("R4 invalid ctx", 32'h0100_0000, 0, 0, 0, 0, 0);
        cfg_ctx = 8'd6; walk("R5 ctx bus err", 32'h0100_0000, 0, 0, 0, 0, 0);
        cfg_ctx = 8'd7; walk("R5 ctx reserved", 32'h0100_0000, 0, 0, 0, 0, 0);
        lat = 0;
        cfg_ctx = 8'd3; walk("R1 back to ctx3", 32'h0134_5000, 1, 0, 0, 0, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule